// File: doc/BRIEF.md
# Pending Interrupt Capture Register

This block collects sixteen interrupt requests from pins and internal event sources into a sixteen-bit pending register. Each bit has its own source and stays set until the sequencer clears it. A bit is filled in one of two ways, chosen per bit by a parameter. Level bits follow their source at every rising clock edge. Edge bits pass through a two-flop synchronizer and an edge detector, and set on a rising transition of the source.

A mask vector and a global enable decide which pending bits may raise a request. Power-down (bit 0) and the executive call (bit 5) ignore both the mask and the enable. Machine error (bit 1) ignores the enable but still obeys its mask bit. A fixed priority encoder reports the lowest-numbered eligible bit, together with a request flag. The sequencer clears one bit at a time with a strobe and a bit index.

Top module: `pend_irq_capture`

## Requirements
- R1: While rst_ni is low, pend_o is all zeros, req_o is 0 and req_idx_o is 0.
- R2: A level bit (every bit not listed in R3) is set at each rising clock edge at which its src_i bit is 1. The bit stays set after the source drops, until it is cleared.
- R3: The edge bits are 2, 8, 10, 11, 13 and 15. An edge bit sets at rising edge M when its source was 1 at edge M-2 and 0 at edge M-3. A source that stays high after its bit is cleared does not set the bit again.
- R4: When clr_i is 1 at a rising edge, bit clr_idx_i of pend_o reads 0 after that edge. All other bits keep their values.
- R5: If a bit is cleared and captured at the same edge, the bit is 1 after that edge.
- R6: A pending bit other than 0 and 5 can raise a request only while its mask_i bit is 1 (1 = allowed). A masked bit stays visible on pend_o.
- R7: A pending bit other than 0, 1 and 5 can raise a request only while gen_i is 1.
- R8: req_o is 1 exactly when some pending bit is eligible. req_idx_o is then the lowest-numbered eligible bit, and it is 0 when no bit is eligible.
- R9: A pending bit 0 or bit 5 raises a request whatever the values of mask_i and gen_i. A pending bit 1 raises a request with gen_i at 0, provided mask_i[1] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Interrupt sources, one per bit |
| mask_i | input | 16 | Per-bit allow mask (1 = allowed) |
| gen_i | input | 1 | Global interrupt enable |
| clr_i | input | 1 | Clear strobe |
| clr_idx_i | input | 4 | Index of the bit to clear |
| pend_o | output | 16 | Pending register contents |
| req_o | output | 1 | An eligible request is pending |
| req_idx_o | output | 4 | Index of the highest-priority eligible bit |

## Verification
The hardest case to reach is an edge bit whose source stays high across its own clear. It must not set again, yet a new rising transition must still be caught three edges after it appears. The stimulus holds a source high, clears the bit while the source is held, and watches several more cycles. A clear that lands on the same edge as a capture is forced as a separate step. Random phases then mix sources, masks, enable and clears, so that clears and captures coincide on many bits and priorities shift. A behavioural model checks every cycle.

// File: rtl/pend_irq_pkg.sv
package pend_irq_pkg;
  localparam int unsigned N_SRC_DEF = 16;
  // bits that ignore the mask, the enable, and which use edge capture
  localparam logic [N_SRC_DEF-1:0] NOMASK_DEF = 16'h0021;
  localparam logic [N_SRC_DEF-1:0] NODIS_DEF  = 16'h0023;
  localparam logic [N_SRC_DEF-1:0] EDGE_DEF   = 16'hAD04;
  localparam int unsigned SYNC_DEF = 2;
endpackage

// File: rtl/pend_irq_edge_det.sv
module pend_irq_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pend_irq_cell.sv
module pend_irq_cell #(
  parameter bit          IS_EDGE = 1'b0,
  parameter int unsigned STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic pend_o
);
  logic set;
  logic pend_q;

  if (IS_EDGE) begin : g_edge
    pend_irq_edge_det #(.STAGES(STAGES)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_i),
      .rise_o(set)
    );
  end else begin : g_level
    assign set = src_i;
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set)   pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pend_irq_arb.sv
module pend_irq_arb #(
  parameter int unsigned     N_SRC  = 16,
  parameter logic [N_SRC-1:0] NOMASK = '0,
  parameter logic [N_SRC-1:0] NODIS  = '0,
  localparam int unsigned    IDX_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             gen_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend_i[i] & (NOMASK[i] | mask_i[i]) & (NODIS[i] | gen_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IDX_W'(i);
    end
  end

  assign req_o = |elig;
endmodule

// File: rtl/pend_irq_capture.sv
module pend_irq_capture
  import pend_irq_pkg::*;
#(
  parameter int unsigned      N_SRC       = N_SRC_DEF,
  parameter logic [N_SRC-1:0] EDGE_BITS   = EDGE_DEF,
  parameter logic [N_SRC-1:0] NOMASK_BITS = NOMASK_DEF,
  parameter logic [N_SRC-1:0] NODIS_BITS  = NODIS_DEF,
  parameter int unsigned      SYNC_STAGES = SYNC_DEF,
  localparam int unsigned     IDX_W       = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             gen_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             req_o,
  output logic [IDX_W-1:0] req_idx_o
);
  logic [N_SRC-1:0] clr_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign clr_vec[i] = clr_i && (clr_idx_i == IDX_W'(i));

    pend_irq_cell #(
      .IS_EDGE(EDGE_BITS[i]),
      .STAGES (SYNC_STAGES)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_i[i]),
      .clr_i (clr_vec[i]),
      .pend_o(pend_o[i])
    );
  end

  pend_irq_arb #(
    .N_SRC (N_SRC),
    .NOMASK(NOMASK_BITS),
    .NODIS (NODIS_BITS)
  ) u_arb (
    .pend_i(pend_o),
    .mask_i(mask_i),
    .gen_i (gen_i),
    .req_o (req_o),
    .idx_o (req_idx_o)
  );
endmodule

// File: rtl/pend_irq_capture_chk.sv
module pend_irq_capture_chk #(
  parameter int unsigned      N_SRC       = 16,
  parameter logic [N_SRC-1:0] EDGE_BITS   = '0,
  parameter logic [N_SRC-1:0] NOMASK_BITS = '0,
  parameter logic [N_SRC-1:0] NODIS_BITS  = '0,
  localparam int unsigned     IDX_W       = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic [N_SRC-1:0] mask_i,
  input logic             gen_i,
  input logic             clr_i,
  input logic [IDX_W-1:0] clr_idx_i,
  input logic [N_SRC-1:0] pend_o,
  input logic             req_o,
  input logic [IDX_W-1:0] req_idx_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (pend_o == '0 && !req_o && req_idx_o == '0);
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prop
    if (!EDGE_BITS[i]) begin : g_lvl
      assert_level_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[i] |=> pend_o[i]);
    end
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !(clr_i && clr_idx_i == IDX_W'(i))) |=> pend_o[i]);
  end

  assert_req_points_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_o[req_idx_o]);
  assert_idle_index_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (req_idx_o == '0));
  assert_mask_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !NOMASK_BITS[req_idx_o]) |-> mask_i[req_idx_o]);
  assert_enable_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !NODIS_BITS[req_idx_o]) |-> gen_i);
  assert_top_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[0] |-> (req_o && req_idx_o == '0));
endmodule

bind pend_irq_capture pend_irq_capture_chk #(
  .N_SRC      (N_SRC),
  .EDGE_BITS  (EDGE_BITS),
  .NOMASK_BITS(NOMASK_BITS),
  .NODIS_BITS (NODIS_BITS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .mask_i   (mask_i),
  .gen_i    (gen_i),
  .clr_i    (clr_i),
  .clr_idx_i(clr_idx_i),
  .pend_o   (pend_o),
  .req_o    (req_o),
  .req_idx_o(req_idx_o)
);

// File: tb/pend_irq_capture_tb.sv
module pend_irq_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EDGE_B = 16'hAD04;
  localparam logic [15:0] NOMASK_B = 16'h0021;
  localparam logic [15:0] NODIS_B = 16'h0023;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src_i = '0;
  logic [15:0] mask_i = '0;
  logic        gen_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [3:0]  clr_idx_i = '0;
  logic [15:0] pend_o;
  logic        req_o;
  logic [3:0]  req_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  logic [15:0] m_pend = '0;
  logic [15:0] hist [0:3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pend_irq_capture u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .mask_i(mask_i),
    .gen_i(gen_i), .clr_i(clr_i), .clr_idx_i(clr_idx_i),
    .pend_o(pend_o), .req_o(req_o), .req_idx_o(req_idx_o)
  );

  // behavioural reference: history of sampled sources per edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0;
      for (int k = 0; k < 4; k++) hist[k] = '0;
    end else begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = src_i;
      for (int i = 0; i < 16; i++) begin
        bit set;
        set = EDGE_B[i] ? (hist[2][i] && !hist[3][i]) : src_i[i];
        if (set) m_pend[i] = 1'b1;
        else if (clr_i && clr_idx_i == 4'(i)) m_pend[i] = 1'b0;
      end
    end
  end

  task automatic compare_all();
    logic exp_req;
    logic [3:0] exp_idx;
    exp_req = 1'b0;
    exp_idx = '0;
    for (int i = 0; i < 16; i++) begin
      if (!exp_req && m_pend[i] && (NOMASK_B[i] || mask_i[i]) && (NODIS_B[i] || gen_i)) begin
        exp_req = 1'b1;
        exp_idx = 4'(i);
      end
    end
    checks++;
    if (pend_o !== m_pend || req_o !== exp_req || req_idx_o !== exp_idx) begin
      failures++;
      $display("FAIL %s: pend=%h req=%b idx=%0d expected pend=%h req=%b idx=%0d",
               tag, pend_o, req_o, req_idx_o, m_pend, exp_req, exp_idx);
    end
  endtask

  task automatic expect_bit(string t, int b, logic v);
    checks++;
    if (pend_o[b] !== v) begin
      failures++;
      $display("FAIL %s: pend[%0d]=%b expected %b", t, b, pend_o[b], v);
    end
  endtask

  task automatic expect_req(string t, logic r, int idx);
    checks++;
    if (req_o !== r || req_idx_o !== 4'(idx)) begin
      failures++;
      $display("FAIL %s: req=%b idx=%0d expected req=%b idx=%0d", t, req_o, req_idx_o, r, idx);
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      compare_all();
      clr_i = 1'b0;
    end
  endtask

  task automatic clear(int b);
    clr_i = 1'b1;
    clr_idx_i = 4'(b);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (pend_o !== '0 || req_o !== 1'b0 || req_idx_o !== '0) begin
      failures++;
      $display("FAIL R1: pend=%h req=%b idx=%0d expected 0 0 0", pend_o, req_o, req_idx_o);
    end
    rst_ni = 1'b1;
    mask_i = '1;
    gen_i = 1'b1;
    step(2);

    tag = "R2";
    src_i[3] = 1'b1; step();
    src_i = '0; step(3);
    expect_bit("R2", 3, 1'b1);

    tag = "R4";
    src_i[6] = 1'b1; step(); src_i = '0;
    clear(3);
    expect_bit("R4", 3, 1'b0);
    expect_bit("R4", 6, 1'b1);
    clear(6);

    tag = "R3";
    src_i[2] = 1'b1; step(2);
    expect_bit("R3", 2, 1'b0);
    step();
    expect_bit("R3", 2, 1'b1);
    clear(2); step(4);
    expect_bit("R3", 2, 1'b0);
    src_i[2] = 1'b0; step(2);
    src_i[2] = 1'b1; step(3);
    expect_bit("R3", 2, 1'b1);
    src_i[2] = 1'b0; clear(2); step(3);

    tag = "R5";
    src_i[4] = 1'b1; clr_i = 1'b1; clr_idx_i = 4'd4; step();
    expect_bit("R5", 4, 1'b1);
    src_i = '0; clear(4);
    expect_bit("R5", 4, 1'b0);

    tag = "R8";
    src_i = 16'h1280; step(); src_i = '0;
    expect_req("R8", 1'b1, 7);
    clear(7); expect_req("R8", 1'b1, 9);
    clear(9); expect_req("R8", 1'b1, 12);
    clear(12); expect_req("R8", 1'b0, 0);

    tag = "R6";
    mask_i[6] = 1'b0;
    src_i[6] = 1'b1; step(); src_i = '0;
    expect_bit("R6", 6, 1'b1);
    expect_req("R6", 1'b0, 0);
    mask_i[6] = 1'b1; step();
    expect_req("R6", 1'b1, 6);
    clear(6);

    tag = "R7";
    gen_i = 1'b0;
    src_i[4] = 1'b1; step(); src_i = '0;
    expect_req("R7", 1'b0, 0);
    src_i[1] = 1'b1; step(); src_i = '0;
    expect_req("R7", 1'b1, 1);
    gen_i = 1'b1;
    clear(1); expect_req("R7", 1'b1, 4);
    clear(4);

    tag = "R9";
    mask_i = '0; gen_i = 1'b0;
    src_i[5] = 1'b1; src_i[1] = 1'b1; step(); src_i = '0;
    expect_req("R9", 1'b1, 5);
    mask_i[1] = 1'b1; step();
    expect_req("R9", 1'b1, 1);
    src_i[0] = 1'b1; step(); src_i = '0;
    expect_req("R9", 1'b1, 0);
    clear(0); clear(1); clear(5);
    expect_req("R9", 1'b0, 0);

    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      src_i = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if (n % 16 == 0) mask_i = 16'($urandom);
      if (n % 32 == 0) gen_i = 1'($urandom);
      clr_idx_i = 4'($urandom);
      clr_i = 1'($urandom);
      @(posedge clk_i);
      @(negedge clk_i);
      compare_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule